// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a synchronous I2C target that lets an external host read and write a small bank of 8-bit registers. It runs entirely on the system clock. SCL and SDA are oversampled through a two-flop synchronizer followed by a three-sample majority vote. The filtered lines feed an edge detector that reports START (including repeated START), STOP, SCL rising and SCL falling. A state machine acts on those events.

The 7-bit target address is formed from a fixed four-bit prefix (`0100`) and three strap pins, which supply the low bits. A write transfer is: address with R/W=0, then a command byte that loads the register pointer, then any number of data bytes. Each data byte produces a one-cycle write strobe carrying the pointer and the byte. A read transfer first sets the pointer this way, then issues a repeated START with R/W=1. For every byte the target sends, it raises a one-cycle read strobe with the pointer, and the register bank may use that strobe to clear side effects. The target never drives a pad directly. Its `sda_oe` output, when high, tells the pad to pull SDA low.

States and transitions:
- IDLE goes to ADDR on any START.
- In ADDR, the eighth bit leads to AACK if the address matches and back to IDLE if it does not.
- AACK drives the acknowledge. At the end of the ninth clock it goes to CMD (write) or RLOAD (read).
- CMD goes to CACK, and CACK goes to WDATA.
- WDATA goes to WACK, and WACK returns to WDATA.
- RLOAD lasts one cycle and goes to RDATA.
- RDATA goes to RACK after the eighth SCL fall.
- In RACK, a host ACK goes back to RLOAD at the ninth fall, and a host NACK goes to IDLE.
- From every state, STOP goes to IDLE and START goes to ADDR.

Top module: `i2c_regport`

## Requirements
- R1: While reset is held, `sda_oe`, `wr_strobe` and `rd_strobe` are low.
- R2: An address byte whose upper seven bits equal `{4'b0100, addr_pins[2:0]}` is acknowledged: `sda_oe` is high throughout the SCL-high phase of the ninth clock. Bit 0 of the address byte is R/W, where 1 means read. The address follows the strap pins.
- R3: A non-matching address is not acknowledged. Every byte after it, up to the next START, is also not acknowledged and produces no strobe.
- R4: In a write transfer, the byte after the address is acknowledged and loads the register pointer.
- R5: Every further write byte is acknowledged and yields a one-cycle `wr_strobe` with `wr_index` equal to the pointer and `wr_data` equal to the byte (first bit on the bus is the MSB). The pointer does not advance.
- R6: After a repeated START with R/W=1, the target raises a one-cycle `rd_strobe` with `rd_index` equal to the pointer and shifts out the returned `rd_data` MSB first.
- R7: A host ACK after a read byte starts another byte, with a new `rd_strobe` and the same index. A host NACK ends the transfer with SDA released and no further strobe.
- R8: `sda_oe` changes only while filtered SCL is low.
- R9: A STOP in any state returns the block to idle with SDA released. A byte cut short by STOP produces no strobe.
- R10: A pulse of one system-clock cycle on SCL or SDA is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| addr_pins | input | 3 | Strap pins giving the low address bits |
| sda_oe | output | 1 | High pulls SDA low |
| wr_strobe | output | 1 | One-cycle register write pulse |
| wr_index | output | 8 | Register index for the write |
| wr_data | output | 8 | Byte to write |
| rd_strobe | output | 1 | One-cycle pulse when a read byte is loaded |
| rd_index | output | 8 | Register index for the read |
| rd_data | input | 8 | Register value, sampled while `rd_strobe` is high |

## Verification
A pad change reaches the filtered line after four or five clocks. The resulting event is acted on at the next edge. So a write strobe appears roughly six clocks after the eighth SCL rise of a data byte, and a read strobe roughly six clocks after the falling edge that ends an acknowledge. The bench drives SCL with 25-clock quarter phases, far longer than this latency, and compares strobes through a scoreboard that pops expected items whenever a strobe is observed rather than at a fixed cycle. Bus-level results (acknowledge, read bits, SDA stability) are sampled in the middle of the SCL-high phase, after every register on the path has settled.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WDATA,
        ST_WACK,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK
    } state_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter
    import i2c_regport_pkg::*;
#(
    parameter int LINES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sync_q;
        logic [2:0]             win_q;
        logic                   clean_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q  <= '1;
                win_q   <= '1;
                clean_q <= 1'b1;
            end else begin
                sync_q  <= {sync_q[SYNC_STAGES-2:0], raw[g]};
                win_q   <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
                clean_q <= maj3(win_q);
            end
        end

        assign clean[g] = clean_q;
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    assign start_ev = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    assign stop_ev  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    assign scl_rise = scl_f & ~scl_prev_q;
    assign scl_fall = ~scl_f & scl_prev_q;

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_PIN_W  = 3,
    parameter logic [6:0] BASE_ADDR   = 7'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [ADDR_PIN_W-1:0] addr_pins,
    output logic                  sda_oe,
    output logic                  wr_strobe,
    output logic [BYTE_W-1:0]     wr_index,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  rd_strobe,
    output logic [BYTE_W-1:0]     rd_index,
    input  logic [BYTE_W-1:0]     rd_data
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [1:0] line_clean;
    logic       scl_f, sda_f;
    logic       start_ev, stop_ev, scl_rise, scl_fall;

    state_t              state_q, state_d;
    logic [BYTE_W-1:0]   shift_q;
    logic [CNT_W-1:0]    bitcnt_q;
    logic                ack_drive_q;
    logic                ack_half_q;
    logic                rw_q;
    logic [BYTE_W-1:0]   ptr_q;
    logic                wr_stb_q;
    logic [BYTE_W-1:0]   wr_data_q;

    logic [BYTE_W-1:0]   rx_byte;
    logic                byte_done;
    logic                addr_hit;

    i2c_line_filter #(
        .LINES      (2),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({scl_i, sda_i}),
        .clean(line_clean)
    );

    assign scl_f = line_clean[1];
    assign sda_f = line_clean[0];

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    assign rx_byte   = {shift_q[BYTE_W-2:0], sda_f};
    assign byte_done = scl_rise && (bitcnt_q == LAST_BIT);
    assign addr_hit  = (rx_byte[7:1] == {BASE_ADDR[6:ADDR_PIN_W], addr_pins});

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_ADDR:  if (byte_done) state_d = addr_hit ? ST_AACK : ST_IDLE;
                ST_AACK:  if (scl_fall && ack_half_q) state_d = rw_q ? ST_RLOAD : ST_CMD;
                ST_CMD:   if (byte_done) state_d = ST_CACK;
                ST_CACK:  if (scl_fall && ack_half_q) state_d = ST_WDATA;
                ST_WDATA: if (byte_done) state_d = ST_WACK;
                ST_WACK:  if (scl_fall && ack_half_q) state_d = ST_WDATA;
                ST_RLOAD: state_d = ST_RDATA;
                ST_RDATA: if (scl_fall && bitcnt_q == LAST_BIT) state_d = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_f)            state_d = ST_IDLE;
                    else if (scl_fall && ack_half_q)  state_d = ST_RLOAD;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bitcnt_q    <= '0;
            ack_drive_q <= 1'b0;
            ack_half_q  <= 1'b0;
            rw_q        <= 1'b0;
            ptr_q       <= '0;
            wr_stb_q    <= 1'b0;
            wr_data_q   <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            if (start_ev || stop_ev) begin
                bitcnt_q    <= '0;
                ack_drive_q <= 1'b0;
                ack_half_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            shift_q  <= rx_byte;
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (bitcnt_q == LAST_BIT) begin
                                ack_half_q <= 1'b0;
                                if (state_q == ST_ADDR) rw_q  <= sda_f;
                                if (state_q == ST_CMD)  ptr_q <= rx_byte;
                                if (state_q == ST_WDATA) begin
                                    wr_stb_q  <= 1'b1;
                                    wr_data_q <= rx_byte;
                                end
                            end
                        end
                    end
                    ST_AACK, ST_CACK, ST_WACK: begin
                        if (scl_fall) begin
                            if (!ack_half_q) begin
                                ack_half_q  <= 1'b1;
                                ack_drive_q <= 1'b1;
                            end else begin
                                ack_half_q  <= 1'b0;
                                ack_drive_q <= 1'b0;
                                bitcnt_q    <= '0;
                            end
                        end
                    end
                    ST_RLOAD: begin
                        shift_q    <= rd_data;
                        bitcnt_q   <= '0;
                        ack_half_q <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_fall && bitcnt_q != LAST_BIT) begin
                            shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && !sda_f) ack_half_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = (state_q == ST_RDATA) ? ~shift_q[BYTE_W-1] : ack_drive_q;
        wr_strobe = wr_stb_q;
        wr_index  = ptr_q;
        wr_data   = wr_data_q;
        rd_strobe = (state_q == ST_RLOAD);
        rd_index  = ptr_q;
    end

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic stop_ev,
    input logic sda_oe,
    input logic wr_strobe,
    input logic rd_strobe
);

    // R8
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && rd_strobe));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe && !rd_strobe));

endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .wr_strobe(wr_strobe),
    .rd_strobe(rd_strobe)
);

// File: tb/i2c_regport_tb.sv
`timescale 1ns/1ps
module i2c_regport_tb;

    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_pins = 3'b101;
    logic       sda_oe, wr_strobe, rd_strobe;
    logic [7:0] wr_index, wr_data, rd_index, rd_data;
    logic       sda_bus;
    logic [7:0] bank [8];
    logic [16:0] exp_q [$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = bank[rd_index[2:0]];

    i2c_regport u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_pins(addr_pins), .sda_oe(sda_oe),
        .wr_strobe(wr_strobe), .wr_index(wr_index), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .rd_index(rd_index), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sb_compare(input logic [16:0] got, input string req);
        logic [16:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, {req, " unexpected strobe"}, got, 17'h0);
        end else begin
            e = exp_q.pop_front();
            check(got == e, req, got, e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe) begin
                sb_compare({1'b0, wr_index, wr_data}, "R5 write strobe");
                bank[wr_index[2:0]] = wr_data;
            end
            if (rd_strobe) sb_compare({1'b1, rd_index, 8'h00}, "R6 read strobe");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit g_scl, input bit g_sda);
        if (g_scl) begin
            tick(5); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q-6);
        end else tick(Q);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (g_sda) begin
            tick(Q); sda_m = ~b; tick(1); sda_m = b; tick(Q-1);
        end else tick(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        logic b0, b2;
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
        tick(2); #1 b0 = sda_bus;
        tick(Q); #1 b = sda_bus;
        tick(Q-3); #1 b2 = sda_bus;
        check(b0 == b && b2 == b, "R8 sda stable while scl high", {b0, b2}, {b, b});
        @(posedge clk); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack, input int gscl_i, input int gsda_i);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i], gscl_i == i, gsda_i == i);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit host_ack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(host_ack ? 1'b0 : 1'b1, 0, 0);
    endtask

    task automatic drain(input string req);
        tick(20);
        check(exp_q.size() == 0, {req, " pending strobes"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // full read of one byte from register idx through the normal interface
    task automatic read_reg(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] expv, input string req);
        bit ack;
        logic [7:0] d;
        exp_q.push_back({1'b1, idx, 8'h00});
        bus_start();
        send_byte({a, 1'b0}, ack, -1, -1); check(ack, {req, " addr ack"}, ack, 1);
        send_byte(idx, ack, -1, -1);       check(ack, {req, " cmd ack"}, ack, 1);
        bus_start();
        send_byte({a, 1'b1}, ack, -1, -1); check(ack, {req, " read addr ack"}, ack, 1);
        recv_byte(d, 1'b0);
        check(d == expv, {req, " read data"}, d, expv);
        bus_stop();
        drain(req);
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) bank[i] = 8'h00;
        tick(10); #1;
        // R1 reset state
        check(!sda_oe && !wr_strobe && !rd_strobe, "R1 reset outputs",
              {sda_oe, wr_strobe, rd_strobe}, 0);
        rst_n = 1'b1;
        tick(20);

        // R2 R4 R5: single write
        exp_q.push_back({1'b0, 8'h03, 8'hA5});
        bus_start();
        send_byte({7'h25, 1'b0}, ack, -1, -1); check(ack, "R2 address ack", ack, 1);
        send_byte(8'h03, ack, -1, -1);         check(ack, "R4 command ack", ack, 1);
        send_byte(8'hA5, ack, -1, -1);         check(ack, "R5 data ack", ack, 1);
        bus_stop();
        drain("R5");

        // R5: pointer does not advance over two bytes
        exp_q.push_back({1'b0, 8'h05, 8'h12});
        exp_q.push_back({1'b0, 8'h05, 8'h34});
        bus_start();
        send_byte({7'h25, 1'b0}, ack, -1, -1);
        send_byte(8'h05, ack, -1, -1);
        send_byte(8'h12, ack, -1, -1); check(ack, "R5 first data ack", ack, 1);
        send_byte(8'h34, ack, -1, -1); check(ack, "R5 second data ack", ack, 1);
        bus_stop();
        drain("R5");

        // R6 R7: two-byte read, ACK then NACK
        exp_q.push_back({1'b1, 8'h03, 8'h00});
        exp_q.push_back({1'b1, 8'h03, 8'h00});
        bus_start();
        send_byte({7'h25, 1'b0}, ack, -1, -1);
        send_byte(8'h03, ack, -1, -1);
        bus_start();
        send_byte({7'h25, 1'b1}, ack, -1, -1); check(ack, "R6 read address ack", ack, 1);
        recv_byte(d, 1'b1); check(d == 8'hA5, "R6 first read byte", d, 8'hA5);
        recv_byte(d, 1'b0); check(d == 8'hA5, "R7 byte after host ack", d, 8'hA5);
        tick(Q); #1 check(!sda_oe, "R7 released after NACK", sda_oe, 0);
        bus_stop();
        drain("R7");

        read_reg(7'h25, 8'h05, 8'h34, "R6 reg5");

        // R3: wrong address ignored
        bus_start();
        send_byte({7'h24, 1'b0}, ack, -1, -1); check(!ack, "R3 no ack on miss", ack, 0);
        send_byte(8'h03, ack, -1, -1);         check(!ack, "R3 no ack on cmd", ack, 0);
        send_byte(8'hFF, ack, -1, -1);         check(!ack, "R3 no ack on data", ack, 0);
        bus_stop();
        drain("R3");
        read_reg(7'h25, 8'h03, 8'hA5, "R3 reg3 kept");

        // R2: strap pins move the address
        addr_pins = 3'b010;
        tick(10);
        bus_start();
        send_byte({7'h25, 1'b0}, ack, -1, -1); check(!ack, "R2 old address rejected", ack, 0);
        bus_stop();
        exp_q.push_back({1'b0, 8'h01, 8'h5A});
        bus_start();
        send_byte({7'h22, 1'b0}, ack, -1, -1); check(ack, "R2 new address ack", ack, 1);
        send_byte(8'h01, ack, -1, -1);
        send_byte(8'h5A, ack, -1, -1);
        bus_stop();
        drain("R2");

        // R9: STOP mid-byte
        bus_start();
        send_byte({7'h22, 1'b0}, ack, -1, -1);
        send_byte(8'h06, ack, -1, -1);
        send_bit(1'b1, 0, 0); send_bit(1'b0, 0, 0);
        send_bit(1'b1, 0, 0); send_bit(1'b1, 0, 0);
        bus_stop();
        #1 check(!sda_oe, "R9 released after stop", sda_oe, 0);
        drain("R9");
        read_reg(7'h22, 8'h06, 8'h00, "R9 reg6 untouched");

        // R10: one-cycle glitches on SCL and SDA
        exp_q.push_back({1'b0, 8'h07, 8'hC3});
        bus_start();
        send_byte({7'h22, 1'b0}, ack, -1, -1);
        send_byte(8'h07, ack, 4, -1);  check(ack, "R10 cmd ack with scl glitch", ack, 1);
        send_byte(8'hC3, ack, -1, 7);  check(ack, "R10 data ack with sda glitch", ack, 1);
        bus_stop();
        drain("R10");
        read_reg(7'h22, 8'h07, 8'hC3, "R10 reg7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule